// File: doc/BRIEF.md
# Serial Audio Frame Receiver

This block sits on the controller side of a time-division serial audio link and turns the incoming bit stream back into words. The link carries one 256-bit frame per sample period. A frame opens with a 16-bit tag slot, followed by twelve 20-bit data slots. The sender raises a frame marker line (`sync`) on a rising bit-clock edge and holds it high for the sixteen tag bits. The serial data runs one bit clock behind that marker. The receiver samples both lines on the falling edge of the bit clock and counts bits from each marker rise. It rebuilds every slot in one shared shift register.

Each bit of the tag word tells whether one data slot holds valid data in the current frame. When a tagged slot ends, its word is placed on a common data bus and one strobe is pulsed, one strobe for each slot. Four slots have fixed roles, and their last valid contents are held on dedicated outputs: register-read address, register-read data, left record sample and right record sample. A record sample keeps the upper 18 bits of its slot. If the marker rises anywhere other than the expected frame boundary, the receiver realigns to it and pulses an error flag.

Top module: `tdm_frame_rx`

## Requirements
- R1: `sync` and `sdin` are sampled only on the falling edge of `bit_clk`. A change on `sdin` that is made and undone between a falling edge and the next rising edge does not alter any output.
- R2: A 0-to-1 change of `sync` seen on a falling edge marks a frame start. The bit sampled on the following falling edge is bit 0 of the frame. The first frame start after reset only aligns the receiver and produces no strobe.
- R3: Frame bits 0..15 form the tag word, most significant bit first. One cycle after bit 15 is sampled, `tag_stb` is high for exactly one cycle and `tag_word` carries the tag.
- R4: Data slot n (1..12) occupies frame bits 16+20(n-1) to 35+20(n-1), most significant bit first. Its word appears on `slot_data` with `slot_stb[n-1]` high for one cycle, updated on the falling edge that samples its last bit. For slot 12, that is the edge on which the next frame start is seen.
- R5: `slot_stb[n-1]` pulses only if tag bit 15-n is 1. Tag bit 15 and tag bits 2..0 gate no slot.
- R6: `stat_addr` takes slot 1 and `stat_data` takes slot 2, and each changes only when its slot's strobe pulses.
- R7: `rec_left` takes bits 19..2 of slot 3 and `rec_right` takes bits 19..2 of slot 4, and each changes only when its slot's strobe pulses.
- R8: A frame start seen at any point other than right after frame bit 254 pulses `sync_err` for one cycle. On that edge, the sampled bit is dropped and the unfinished slot is discarded, and counting restarts at bit 0.
- R9: Bits past 256 in an overlong frame are ignored, and the frame start that ends such a frame raises `sync_err`.
- R10: After reset, every output is zero.
- R11: At most one bit of `slot_stb` is high in any cycle, and it never coincides with `tag_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync | input | 1 | Frame marker, high during the tag bits |
| sdin | input | 1 | Serial data, one bit clock behind the marker |
| tag_stb | output | 1 | One-cycle pulse when the tag word is complete |
| tag_word | output | 16 | Tag word of the current frame |
| slot_stb | output | 12 | One-cycle pulse per data slot; bit n-1 belongs to slot n |
| slot_data | output | 20 | Word of the slot whose strobe last pulsed |
| stat_addr | output | 20 | Held contents of slot 1 (register-read address) |
| stat_data | output | 20 | Held contents of slot 2 (register-read data) |
| rec_left | output | 18 | Held upper 18 bits of slot 3 |
| rec_right | output | 18 | Held upper 18 bits of slot 4 |
| sync_err | output | 1 | One-cycle pulse on a misplaced frame start |

## Verification
A misplaced frame start and the end of a data slot can fall on the same falling edge. The bench forces this by cutting a frame to 76 bits, so that the early marker rise lands on the edge that would sample the last bit of slot 3, which is tagged valid. The expected result is an error pulse with no strobe and an unchanged `rec_left`, followed by a fully correct next frame. Cuts at random lengths and an overlong frame then exercise resynchronisation against the counter's other positions.

// File: rtl/tdm_rx_pkg.sv
`timescale 1ns/1ps
package tdm_rx_pkg;
    localparam int unsigned TAG_BITS_DEF    = 16;
    localparam int unsigned SLOT_BITS_DEF   = 20;
    localparam int unsigned NUM_SLOTS_DEF   = 12;
    localparam int unsigned SAMPLE_BITS_DEF = 18;
    // slot roles (1-based slot numbers)
    localparam int unsigned ADDR_SLOT  = 1;
    localparam int unsigned DATA_SLOT  = 2;
    localparam int unsigned LEFT_SLOT  = 3;
    localparam int unsigned RIGHT_SLOT = 4;

    // slot index 0 is the tag slot, NUM_SLOTS+1 is the idle state after a frame
    function automatic int unsigned idx_width(int unsigned n_slots);
        return $clog2(n_slots + 2);
    endfunction
endpackage

// File: rtl/tdm_rx_align.sv
`timescale 1ns/1ps
module tdm_rx_align
    import tdm_rx_pkg::*;
#(
    parameter int unsigned TAG_BITS  = TAG_BITS_DEF,
    parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
    parameter int unsigned NUM_SLOTS = NUM_SLOTS_DEF,
    parameter int unsigned IDX_W     = idx_width(NUM_SLOTS)
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             cap_en,
    output logic             last_bit,
    output logic [IDX_W-1:0] slot_idx,
    output logic             sync_err
);
    localparam int unsigned POS_W = $clog2(SLOT_BITS);

    typedef struct packed {
        logic             sync_prev;
        logic             locked;
        logic [IDX_W-1:0] slot;
        logic [POS_W-1:0] pos;
        logic             err;
    } align_t;

    align_t s_d, s_q;
    logic   rise, aligned, in_frame, slot_end;

    always_comb begin
        rise     = sync & ~s_q.sync_prev;
        in_frame = s_q.locked && (s_q.slot <= IDX_W'(NUM_SLOTS));
        slot_end = (s_q.slot == '0) ? (s_q.pos == POS_W'(TAG_BITS - 1))
                                    : (s_q.pos == POS_W'(SLOT_BITS - 1));
        aligned  = (s_q.slot == IDX_W'(NUM_SLOTS)) && (s_q.pos == POS_W'(SLOT_BITS - 1));
        cap_en   = in_frame && (!rise || aligned);
        last_bit = cap_en && slot_end;

        s_d           = s_q;
        s_d.sync_prev = sync;
        s_d.err       = 1'b0;
        if (rise) begin
            s_d.locked = 1'b1;
            s_d.slot   = '0;
            s_d.pos    = '0;
            s_d.err    = s_q.locked && !aligned;
        end else if (cap_en) begin
            if (slot_end) begin
                s_d.pos  = '0;
                s_d.slot = s_q.slot + 1'b1;
            end else begin
                s_d.pos  = s_q.pos + 1'b1;
            end
        end
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign slot_idx = s_q.slot;
    assign sync_err = s_q.err;
endmodule

// File: rtl/tdm_rx_shift.sv
`timescale 1ns/1ps
module tdm_rx_shift
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
    input  logic                 bit_clk,
    input  logic                 rst_n,
    input  logic                 cap_en,
    input  logic                 sdin,
    output logic [SLOT_BITS-1:0] word
);
    logic [SLOT_BITS-2:0] sh_d, sh_q;

    always_comb begin
        word = {sh_q, sdin};
        sh_d = cap_en ? word[SLOT_BITS-2:0] : sh_q;
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/tdm_rx_route.sv
`timescale 1ns/1ps
module tdm_rx_route
    import tdm_rx_pkg::*;
#(
    parameter int unsigned TAG_BITS    = TAG_BITS_DEF,
    parameter int unsigned SLOT_BITS   = SLOT_BITS_DEF,
    parameter int unsigned NUM_SLOTS   = NUM_SLOTS_DEF,
    parameter int unsigned SAMPLE_BITS = SAMPLE_BITS_DEF,
    parameter int unsigned IDX_W       = idx_width(NUM_SLOTS)
) (
    input  logic                   bit_clk,
    input  logic                   rst_n,
    input  logic                   last_bit,
    input  logic [IDX_W-1:0]       slot_idx,
    input  logic [SLOT_BITS-1:0]   word,
    output logic                   tag_stb,
    output logic [TAG_BITS-1:0]    tag_word,
    output logic [NUM_SLOTS-1:0]   slot_stb,
    output logic [SLOT_BITS-1:0]   slot_data,
    output logic [SLOT_BITS-1:0]   stat_addr,
    output logic [SLOT_BITS-1:0]   stat_data,
    output logic [SAMPLE_BITS-1:0] rec_left,
    output logic [SAMPLE_BITS-1:0] rec_right
);
    typedef struct packed {
        logic [TAG_BITS-1:0]    tag;
        logic                   tag_stb;
        logic [NUM_SLOTS-1:0]   stb;
        logic [SLOT_BITS-1:0]   data;
        logic [SLOT_BITS-1:0]   addr;
        logic [SLOT_BITS-1:0]   sdat;
        logic [SAMPLE_BITS-1:0] left;
        logic [SAMPLE_BITS-1:0] right;
    } route_t;

    route_t               r_d, r_q;
    logic [NUM_SLOTS-1:0] slot_en;

    // tag bit just below the frame-valid bit enables slot 1, and so on downwards
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_en
        assign slot_en[g] = r_q.tag[TAG_BITS-2-g];
    end

    always_comb begin
        r_d         = r_q;
        r_d.tag_stb = 1'b0;
        r_d.stb     = '0;
        if (last_bit) begin
            if (slot_idx == '0) begin
                r_d.tag     = word[TAG_BITS-1:0];
                r_d.tag_stb = 1'b1;
            end else begin
                for (int n = 0; n < NUM_SLOTS; n++) begin
                    if (slot_idx == IDX_W'(n + 1) && slot_en[n]) begin
                        r_d.stb[n] = 1'b1;
                        r_d.data   = word;
                    end
                end
            end
        end
        if (r_d.stb[ADDR_SLOT-1])  r_d.addr  = word;
        if (r_d.stb[DATA_SLOT-1])  r_d.sdat  = word;
        if (r_d.stb[LEFT_SLOT-1])  r_d.left  = word[SLOT_BITS-1 -: SAMPLE_BITS];
        if (r_d.stb[RIGHT_SLOT-1]) r_d.right = word[SLOT_BITS-1 -: SAMPLE_BITS];
    end

    always_ff @(negedge bit_clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tag_stb   = r_q.tag_stb;
    assign tag_word  = r_q.tag;
    assign slot_stb  = r_q.stb;
    assign slot_data = r_q.data;
    assign stat_addr = r_q.addr;
    assign stat_data = r_q.sdat;
    assign rec_left  = r_q.left;
    assign rec_right = r_q.right;
endmodule

// File: rtl/tdm_frame_rx.sv
`timescale 1ns/1ps
module tdm_frame_rx
    import tdm_rx_pkg::*;
#(
    parameter int unsigned TAG_BITS    = TAG_BITS_DEF,
    parameter int unsigned SLOT_BITS   = SLOT_BITS_DEF,
    parameter int unsigned NUM_SLOTS   = NUM_SLOTS_DEF,
    parameter int unsigned SAMPLE_BITS = SAMPLE_BITS_DEF
) (
    input  logic                   bit_clk,
    input  logic                   rst_n,
    input  logic                   sync,
    input  logic                   sdin,
    output logic                   tag_stb,
    output logic [TAG_BITS-1:0]    tag_word,
    output logic [NUM_SLOTS-1:0]   slot_stb,
    output logic [SLOT_BITS-1:0]   slot_data,
    output logic [SLOT_BITS-1:0]   stat_addr,
    output logic [SLOT_BITS-1:0]   stat_data,
    output logic [SAMPLE_BITS-1:0] rec_left,
    output logic [SAMPLE_BITS-1:0] rec_right,
    output logic                   sync_err
);
    localparam int unsigned IDX_W = idx_width(NUM_SLOTS);

    logic                 cap_en, last_bit;
    logic [IDX_W-1:0]     slot_idx;
    logic [SLOT_BITS-1:0] word;

    tdm_rx_align #(
        .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS),
        .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
    ) u_align (
        .bit_clk(bit_clk), .rst_n(rst_n), .sync(sync),
        .cap_en(cap_en), .last_bit(last_bit),
        .slot_idx(slot_idx), .sync_err(sync_err)
    );

    tdm_rx_shift #(.SLOT_BITS(SLOT_BITS)) u_shift (
        .bit_clk(bit_clk), .rst_n(rst_n), .cap_en(cap_en),
        .sdin(sdin), .word(word)
    );

    tdm_rx_route #(
        .TAG_BITS(TAG_BITS), .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS),
        .SAMPLE_BITS(SAMPLE_BITS), .IDX_W(IDX_W)
    ) u_route (
        .bit_clk(bit_clk), .rst_n(rst_n), .last_bit(last_bit),
        .slot_idx(slot_idx), .word(word),
        .tag_stb(tag_stb), .tag_word(tag_word),
        .slot_stb(slot_stb), .slot_data(slot_data),
        .stat_addr(stat_addr), .stat_data(stat_data),
        .rec_left(rec_left), .rec_right(rec_right)
    );
endmodule

// File: rtl/tdm_rx_chk.sv
`timescale 1ns/1ps
module tdm_rx_chk
    import tdm_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS   = SLOT_BITS_DEF,
    parameter int unsigned NUM_SLOTS   = NUM_SLOTS_DEF,
    parameter int unsigned SAMPLE_BITS = SAMPLE_BITS_DEF
) (
    input logic                   bit_clk,
    input logic                   rst_n,
    input logic                   tag_stb,
    input logic                   sync_err,
    input logic [NUM_SLOTS-1:0]   slot_stb,
    input logic [SLOT_BITS-1:0]   stat_addr,
    input logic [SAMPLE_BITS-1:0] rec_left
);
    // R11
    one_slot_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        $onehot0(slot_stb));
    // R11
    tag_apart_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !(tag_stb && (slot_stb != '0)));
    // R4
    stb_pulse_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        (slot_stb != '0) |=> (slot_stb == '0));
    // R3
    tag_pulse_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        tag_stb |=> !tag_stb);
    // R8
    err_quiet_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        sync_err |-> (slot_stb == '0) && !tag_stb);
    // R8
    err_pulse_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        sync_err |=> !sync_err);
    // R6
    addr_hold_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !slot_stb[ADDR_SLOT-1] |-> $stable(stat_addr));
    // R7
    left_hold_chk: assert property (@(negedge bit_clk) disable iff (!rst_n)
        !slot_stb[LEFT_SLOT-1] |-> $stable(rec_left));
endmodule

bind tdm_frame_rx tdm_rx_chk #(
    .SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS), .SAMPLE_BITS(SAMPLE_BITS)
) u_chk (
    .bit_clk(bit_clk), .rst_n(rst_n), .tag_stb(tag_stb), .sync_err(sync_err),
    .slot_stb(slot_stb), .stat_addr(stat_addr), .rec_left(rec_left)
);

// File: tb/sim_tdm_frame_rx.sv
`timescale 1ns/1ps
module sim_tdm_frame_rx;
    logic        clk = 1'b0, rst_n = 1'b0, sync = 1'b0, sdin = 1'b0;
    logic        tag_stb, sync_err;
    logic [15:0] tag_word;
    logic [11:0] slot_stb;
    logic [19:0] slot_data, stat_addr, stat_data;
    logic [17:0] rec_left, rec_right;

    tdm_frame_rx u0 (
        .bit_clk(clk), .rst_n(rst_n), .sync(sync), .sdin(sdin),
        .tag_stb(tag_stb), .tag_word(tag_word), .slot_stb(slot_stb),
        .slot_data(slot_data), .stat_addr(stat_addr), .stat_data(stat_data),
        .rec_left(rec_left), .rec_right(rec_right), .sync_err(sync_err)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic        tag_stb;
        logic [15:0] tag_word;
        logic [11:0] stb;
        logic [19:0] data;
        logic        err;
    } exp_t;

    exp_t        cexp = '0, nexp = '0, carry_exp = '0;
    int          total = 0, fails = 0, prev_len = 256;
    string       ctx = "reset";
    bit          done = 0, have_prev = 0;
    logic [19:0] e_addr = '0, e_sdat = '0;
    logic [17:0] e_left = '0, e_right = '0;
    logic [15:0] tag_v = '0;
    logic [19:0] slots_v [12];
    logic        fr [0:299];
    logic        carry_bit = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s (%s): actual %h expected %h", req, ctx, act, exp);
        end
    endtask

    // expected event for the frame bit with index e, from the layout rules
    function automatic exp_t exp_for(input int e);
        exp_t x = '0;
        int   n;
        if (e == 15) begin
            x.tag_stb  = 1'b1;
            x.tag_word = tag_v;
        end else if (e >= 35 && e <= 255 && (e - 15) % 20 == 0) begin
            n = (e - 15) / 20;
            if (tag_v[15-n]) begin
                x.stb[n-1] = 1'b1;
                x.data     = slots_v[n-1];
            end
        end
        return x;
    endfunction

    task automatic step(input logic s, input logic d, input bit glitch);
        @(posedge clk);
        cexp = nexp;
        nexp = '0;
        if (cexp.stb[0]) e_addr  = cexp.data;
        if (cexp.stb[1]) e_sdat  = cexp.data;
        if (cexp.stb[2]) e_left  = cexp.data[19:2];
        if (cexp.stb[3]) e_right = cexp.data[19:2];
        check("R3", {47'h0, tag_stb, tag_stb ? tag_word : 16'h0},
                    {47'h0, cexp.tag_stb, cexp.tag_word});
        check("R5", 64'(slot_stb), 64'(cexp.stb));
        if (cexp.stb != '0) check("R4", 64'(slot_data), 64'(cexp.data));
        check("R8", 64'(sync_err), 64'(cexp.err));
        check("R6", {24'h0, stat_addr, stat_data}, {24'h0, e_addr, e_sdat});
        check("R7", {28'h0, rec_left, rec_right}, {28'h0, e_left, e_right});
        check("R11", 64'($countones(slot_stb) <= 1), 64'd1);
        sync = s;
        sdin = d;
        if (glitch) begin
            #2.5 sdin = ~d;
            #1   sdin = d;
        end
    endtask

    task automatic rand_frame();
        tag_v = 16'($urandom);
        for (int n = 0; n < 12; n++) slots_v[n] = 20'($urandom);
    endtask

    task automatic send_frame(input int len, input bit glitch);
        for (int i = 0; i < 300; i++) fr[i] = 1'($urandom);
        for (int i = 0; i < 16; i++) fr[i] = tag_v[15-i];
        for (int n = 0; n < 12; n++)
            for (int k = 0; k < 20; k++) fr[16 + 20*n + k] = slots_v[n][19-k];
        // marker rise carries the last bit of the previous frame
        step(1'b1, carry_bit, glitch);
        nexp     = have_prev ? carry_exp : '0;
        nexp.err = have_prev && (prev_len != 256);
        for (int i = 1; i < len; i++) begin
            step(i < 16, fr[i-1], glitch);
            nexp = exp_for(i - 1);
        end
        carry_bit = fr[len-1];
        carry_exp = (len == 256) ? exp_for(255) : '0;
        have_prev = 1;
        prev_len  = len;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int n = 0; n < 12; n++) slots_v[n] = '0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        ctx = "R10 reset";
        check("R10", {14'h0, tag_stb, tag_word, slot_stb, slot_data, sync_err}, 64'h0);
        check("R10", {24'h0, stat_addr, stat_data}, 64'h0);
        check("R10", {28'h0, rec_left, rec_right}, 64'h0);

        ctx = "R2 first frame after reset";
        rand_frame(); tag_v = 16'hFFFF;
        send_frame(256, 0);
        ctx = "R5 empty tag";
        rand_frame(); tag_v = 16'h0000;
        send_frame(256, 0);
        ctx = "R5 non-gating tag bits only";
        rand_frame(); tag_v = 16'h8007;
        send_frame(256, 0);
        ctx = "R4 random frames";
        repeat (10) begin rand_frame(); send_frame(256, 0); end
        ctx = "R1 glitch after falling edge";
        repeat (2) begin rand_frame(); tag_v[14:11] = 4'hF; send_frame(256, 1); end

        ctx = "R8 early marker on slot 3 last bit";
        rand_frame(); tag_v[14:11] = 4'hF;
        send_frame(76, 0);
        ctx = "R8 frame after cut";
        rand_frame(); tag_v[14:11] = 4'hF;
        send_frame(256, 0);
        ctx = "R8 random cuts";
        repeat (4) begin rand_frame(); send_frame(40 + int'($urandom % 200), 0); end
        rand_frame(); send_frame(256, 0);

        ctx = "R9 overlong frame";
        rand_frame(); tag_v[14:11] = 4'hF;
        send_frame(270, 0);
        ctx = "R9 frame after overlong";
        rand_frame(); send_frame(256, 0);
        ctx = "R4 closing frames";
        repeat (2) begin rand_frame(); tag_v[3] = 1'b1; send_frame(256, 0); end
        step(1'b1, carry_bit, 0);
        nexp = carry_exp;
        step(1'b0, 1'b0, 0);
        finish_run();
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (%s): actual timeout expected completion", ctx);
            finish_run();
        end
    end
endmodule